// File: doc/BRIEF.md
# Packed Half-Precision Operand Formatter

This block prepares one source operand for a two-lane half-precision datapath. From a 32-bit input word it builds two 16-bit lane values. The word can be read as a pair of halves, as one half copied to both lanes, or as a single-precision value that is narrowed to half precision and copied to both lanes. After that, each lane gets an optional subnormal flush and the sign modifiers: magnitude first, then sign inversion.

The source kind sets which controls the operand may use. A register operand uses all of them. A constant operand is always narrowed from single precision and never takes the magnitude modifier. An immediate operand arrives as two 10-bit fields that hold the top bits of each half, and it ignores every swizzle and sign control. The result is registered: every valid input gives one output pair one clock later.

Top module: `opfmt_top`

## Requirements
- R1: While reset is active, `out_valid` is 0 and both lanes are 16'h0000.
- R2: `out_valid` equals the previous cycle's `in_valid`. When `in_valid` was low, both lanes hold their values.
- R3: Swizzle code 2'b00 puts word bits 15:0 on lane 0 and bits 31:16 on lane 1. Kind codes are 2'b00 register, 2'b01 constant, 2'b10 immediate, and 2'b11 behaves as register.
- R4: Swizzle code 2'b10 copies bits 15:0 to both lanes. Code 2'b11 copies bits 31:16 to both lanes.
- R5: Swizzle code 2'b01 narrows the word from single to half precision with round toward zero (extra mantissa bits are dropped) and puts the result on both lanes.
- R6: In narrowing, a finite value at or above 2^16 in magnitude gives 16'h7BFF or 16'hFBFF, matching its sign. Infinities give 16'h7C00 or 16'hFC00.
- R7: In narrowing, any NaN gives 16'h7E00 for a positive sign and 16'hFE00 for a negative one.
- R8: In narrowing, any value below 2^-14 in magnitude, zero included, gives a zero with the input's sign. A value of exactly 2^-14 gives 16'h0400.
- R9: With `ftz_en` set, a lane that is subnormal (exponent field 0, mantissa not 0) becomes zero with its sign kept. With `ftz_en` clear, a subnormal lane passes through unchanged.
- R10: `abs_en` clears the lane sign bit. `neg_en` then inverts it.
- R11: For an immediate operand, lane 0 is {`imm_lo`, 6'b0} and lane 1 is {`imm_hi`, 6'b0}. `src_word`, `swz_mode`, `neg_en` and `abs_en` have no effect.
- R12: For a constant operand, narrowing is always used whatever `swz_mode` holds, and `abs_en` has no effect. `neg_en` still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand request valid |
| src_word | input | 32 | Register or constant word |
| src_kind | input | 2 | Source kind code |
| swz_mode | input | 2 | Swizzle code |
| neg_en | input | 1 | Invert lane signs |
| abs_en | input | 1 | Clear lane signs |
| ftz_en | input | 1 | Flush subnormal lanes |
| imm_hi | input | 10 | Top bits of the lane 1 immediate |
| imm_lo | input | 10 | Top bits of the lane 0 immediate |
| out_valid | output | 1 | Result valid |
| lane0 | output | 16 | Lane 0 half value |
| lane1 | output | 16 | Lane 1 half value |

## Verification
On every cycle the assertions check several properties: valid timing and hold, lane equality under the replicating swizzles, the absence of subnormals after narrowing, sign handling for constant operands, the zero low bits of immediates, and sign clearing under the magnitude modifier. The exact values need the bench's scenarios. These include truncation of single-precision mantissas, the saturation and infinity boundaries, NaN quieting, the smallest normal exponent, flush behaviour with and without the flag, and how the sign modifiers combine.

// File: rtl/opfmt_pkg.sv
package opfmt_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int IMM_W   = 10;
    localparam int NLANE   = 2;
    localparam int SEXP_W  = 8;
    localparam int SMAN_W  = 23;
    localparam int HEXP_W  = 5;
    localparam int HMAN_W  = 10;
    localparam int SBIAS   = 127;
    localparam int HBIAS   = 15;
    localparam int REBIAS  = SBIAS - HBIAS;
    localparam int HEXP_MAX = (1 << HEXP_W) - 1;
    localparam int DROP_W  = SMAN_W - HMAN_W;

    typedef enum logic [1:0] {
        SWZ_PAIR = 2'b00,
        SWZ_WIDE = 2'b01,
        SWZ_LOW  = 2'b10,
        SWZ_HIGH = 2'b11
    } swz_e;

    typedef enum logic [1:0] {
        KIND_REG   = 2'b00,
        KIND_CONST = 2'b01,
        KIND_IMM   = 2'b10,
        KIND_ALT   = 2'b11
    } kind_e;

    typedef struct packed {
        logic              valid;
        logic [HALF_W-1:0] lane0;
        logic [HALF_W-1:0] lane1;
    } opfmt_state_t;
endpackage

// File: rtl/opfmt_f32_to_h.sv
module opfmt_f32_to_h
    import opfmt_pkg::*;
(
    input  logic [WORD_W-1:0] wide_i,
    output logic [HALF_W-1:0] half_o
);
    localparam logic [SEXP_W-1:0] EXP_ALL1   = '1;
    localparam logic [SEXP_W-1:0] EXP_FLOOR  = SEXP_W'(REBIAS);
    localparam logic [SEXP_W-1:0] EXP_CEIL   = SEXP_W'(REBIAS + HEXP_MAX);
    localparam logic [HEXP_W-1:0] REB_LOW    = HEXP_W'(REBIAS);

    logic              sgn;
    logic [SEXP_W-1:0] exp_s;
    logic [SMAN_W-1:0] man_s;
    logic              man_nz;
    logic [HEXP_W-1:0] exp_h;

    always_comb begin
        sgn    = wide_i[WORD_W-1];
        exp_s  = wide_i[WORD_W-2 -: SEXP_W];
        man_s  = wide_i[SMAN_W-1:0];
        man_nz = |man_s;
        exp_h  = exp_s[HEXP_W-1:0] - REB_LOW;
        if (exp_s == EXP_ALL1) begin
            if (man_nz)
                half_o = {sgn, {HEXP_W{1'b1}}, 1'b1, {(HMAN_W-1){1'b0}}};
            else
                half_o = {sgn, {HEXP_W{1'b1}}, {HMAN_W{1'b0}}};
        end else if (exp_s >= EXP_CEIL) begin
            half_o = {sgn, {(HEXP_W-1){1'b1}}, 1'b0, {HMAN_W{1'b1}}};
        end else if (exp_s <= EXP_FLOOR) begin
            half_o = {sgn, {(HALF_W-1){1'b0}}};
        end else begin
            half_o = {sgn, exp_h, man_s[SMAN_W-1 -: HMAN_W]};
        end
    end
endmodule

// File: rtl/opfmt_lane_mod.sv
module opfmt_lane_mod
    import opfmt_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    input  logic              ftz_i,
    input  logic              abs_i,
    input  logic              neg_i,
    output logic [HALF_W-1:0] half_o
);
    logic              is_sub;
    logic [HALF_W-1:0] flushed;
    logic              sgn;

    always_comb begin
        is_sub  = (half_i[HALF_W-2 -: HEXP_W] == '0) && (half_i[HMAN_W-1:0] != '0);
        flushed = (ftz_i && is_sub) ? {half_i[HALF_W-1], {(HALF_W-1){1'b0}}} : half_i;
        sgn     = (flushed[HALF_W-1] & ~abs_i) ^ neg_i;
        half_o  = {sgn, flushed[HALF_W-2:0]};
    end
endmodule

// File: rtl/opfmt_top.sv
module opfmt_top
    import opfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] src_word,
    input  logic [1:0]        src_kind,
    input  logic [1:0]        swz_mode,
    input  logic              neg_en,
    input  logic              abs_en,
    input  logic              ftz_en,
    input  logic [IMM_W-1:0]  imm_hi,
    input  logic [IMM_W-1:0]  imm_lo,
    output logic              out_valid,
    output logic [HALF_W-1:0] lane0,
    output logic [HALF_W-1:0] lane1
);
    localparam int PAD_W = HALF_W - IMM_W;

    kind_e              kind;
    swz_e               eff_swz;
    logic               eff_neg;
    logic               eff_abs;
    logic [WORD_W-1:0]  raw_word;
    logic [HALF_W-1:0]  conv_half;
    logic [HALF_W-1:0]  pre_lane [NLANE];
    logic [HALF_W-1:0]  mod_lane [NLANE];
    opfmt_state_t       st_d, st_q;

    always_comb begin
        kind     = kind_e'(src_kind);
        eff_swz  = swz_e'(swz_mode);
        eff_neg  = neg_en;
        eff_abs  = abs_en;
        raw_word = src_word;
        case (kind)
            KIND_IMM: begin
                eff_swz  = SWZ_PAIR;
                eff_neg  = 1'b0;
                eff_abs  = 1'b0;
                raw_word = {imm_hi, {PAD_W{1'b0}}, imm_lo, {PAD_W{1'b0}}};
            end
            KIND_CONST: begin
                eff_swz  = SWZ_WIDE;
                eff_abs  = 1'b0;
            end
            default: ;
        endcase
    end

    opfmt_f32_to_h u_conv (
        .wide_i (raw_word),
        .half_o (conv_half)
    );

    always_comb begin
        case (eff_swz)
            SWZ_PAIR: begin
                pre_lane[0] = raw_word[HALF_W-1:0];
                pre_lane[1] = raw_word[WORD_W-1:HALF_W];
            end
            SWZ_LOW: begin
                pre_lane[0] = raw_word[HALF_W-1:0];
                pre_lane[1] = raw_word[HALF_W-1:0];
            end
            SWZ_HIGH: begin
                pre_lane[0] = raw_word[WORD_W-1:HALF_W];
                pre_lane[1] = raw_word[WORD_W-1:HALF_W];
            end
            default: begin
                pre_lane[0] = conv_half;
                pre_lane[1] = conv_half;
            end
        endcase
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        opfmt_lane_mod u_mod (
            .half_i (pre_lane[g]),
            .ftz_i  (ftz_en),
            .abs_i  (eff_abs),
            .neg_i  (eff_neg),
            .half_o (mod_lane[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.lane0 = mod_lane[0];
            st_d.lane1 = mod_lane[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign lane0     = st_q.lane0;
    assign lane1     = st_q.lane1;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(lane0) && $stable(lane1)));
    a_r4_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (eff_swz != SWZ_PAIR)) |=> (lane0 == lane1));
    a_r8_no_subnormal_after_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (eff_swz == SWZ_WIDE)) |=>
        !((lane0[HALF_W-2 -: HEXP_W] == '0) && (lane0[HMAN_W-1:0] != '0)));
    a_r10_abs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && abs_en && !neg_en && (src_kind == KIND_REG)) |=>
        (!lane0[HALF_W-1] && !lane1[HALF_W-1]));
    a_r11_imm_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_kind == KIND_IMM)) |=>
        ((lane0[PAD_W-1:0] == '0) && (lane1[PAD_W-1:0] == '0) &&
         (lane1[HALF_W-1] == $past(imm_hi[IMM_W-1]))));
    a_r12_const_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_kind == KIND_CONST)) |=>
        (lane0[HALF_W-1] == ($past(src_word[WORD_W-1]) ^ $past(neg_en))));
endmodule

// File: tb/opfmt_top_tb_top.sv
`timescale 1ns/1ps
module opfmt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_word = '0;
    logic [1:0]  src_kind = '0;
    logic [1:0]  swz_mode = '0;
    logic        neg_en = 1'b0;
    logic        abs_en = 1'b0;
    logic        ftz_en = 1'b0;
    logic [9:0]  imm_hi = '0;
    logic [9:0]  imm_lo = '0;
    logic        out_valid;
    logic [15:0] lane0, lane1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] e0;
        logic [15:0] e1;
        string       tag;
    } exp_t;
    exp_t sb_q [$];

    always #4 clk = ~clk;

    opfmt_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
        .src_kind(src_kind), .swz_mode(swz_mode), .neg_en(neg_en),
        .abs_en(abs_en), .ftz_en(ftz_en), .imm_hi(imm_hi), .imm_lo(imm_lo),
        .out_valid(out_valid), .lane0(lane0), .lane1(lane1)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic send(input logic [31:0] w, input logic [1:0] k, input logic [1:0] s,
                        input logic n, input logic a, input logic f,
                        input logic [9:0] hi, input logic [9:0] lo,
                        input logic [15:0] e0, input logic [15:0] e1, input string tag);
        exp_t item;
        @(negedge clk);
        in_valid = 1'b1; src_word = w; src_kind = k; swz_mode = s;
        neg_en = n; abs_en = a; ftz_en = f; imm_hi = hi; imm_lo = lo;
        item.e0 = e0; item.e1 = e1; item.tag = tag;
        sb_q.push_back(item);
    endtask

    // monitor: compares each produced pair against the scoreboard
    always begin
        @(posedge clk);
        #1;
        if (rst_n && out_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected output actual=%h/%h expected=none", lane0, lane1);
            end else begin
                exp_t item;
                item = sb_q.pop_front();
                if (lane0 !== item.e0 || lane1 !== item.e1) begin
                    failures++;
                    $display("FAIL %s actual=%h/%h expected=%h/%h",
                             item.tag, lane0, lane1, item.e0, item.e1);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic [15:0] h0, h1;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || lane0 !== 16'h0 || lane1 !== 16'h0) begin
            failures++;
            $display("FAIL R1 reset actual=%b %h/%h expected=0 0000/0000", out_valid, lane0, lane1);
        end
        rst_n = 1'b1;

        // register operands, swizzles
        send(32'h4000_3C00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 16'h3C00, 16'h4000, "R3 pair");
        send(32'h4000_3C00, 2'b11, 2'b00, 0, 0, 0, 0, 0, 16'h3C00, 16'h4000, "R3 kind 11 as register");
        send(32'hC500_3555, 2'b00, 2'b10, 0, 0, 0, 0, 0, 16'h3555, 16'h3555, "R4 low replicate");
        send(32'hC500_3555, 2'b00, 2'b11, 0, 0, 0, 0, 0, 16'hC500, 16'hC500, "R4 high replicate");
        // narrowing
        send(32'h3F80_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h3C00, 16'h3C00, "R5 one");
        send(32'h3F80_1FFF, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h3C00, 16'h3C00, "R5 truncate");
        send(32'h3FC0_2000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h3E01, 16'h3E01, "R5 mantissa");
        send(32'hC000_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'hC000, 16'hC000, "R5 negative");
        send(32'h477F_FF00, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h7BFF, 16'h7BFF, "R6 just below range");
        send(32'h4780_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h7BFF, 16'h7BFF, "R6 overflow pos");
        send(32'hC780_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'hFBFF, 16'hFBFF, "R6 overflow neg");
        send(32'h7F80_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h7C00, 16'h7C00, "R6 inf pos");
        send(32'hFF80_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'hFC00, 16'hFC00, "R6 inf neg");
        send(32'h7FC0_0001, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h7E00, 16'h7E00, "R7 nan pos");
        send(32'hFF80_0001, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'hFE00, 16'hFE00, "R7 nan neg low payload");
        send(32'h3880_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h0400, 16'h0400, "R8 smallest normal");
        send(32'h3800_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h0000, 16'h0000, "R8 below normal");
        send(32'hB800_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h8000, 16'h8000, "R8 below normal neg");
        send(32'h0000_0000, 2'b00, 2'b01, 0, 0, 0, 0, 0, 16'h0000, 16'h0000, "R8 zero");
        // flush and sign modifiers
        send(32'h8001_0200, 2'b00, 2'b00, 0, 0, 1, 0, 0, 16'h0000, 16'h8000, "R9 flush on");
        send(32'h8001_0200, 2'b00, 2'b00, 0, 0, 0, 0, 0, 16'h0200, 16'h8001, "R9 flush off");
        send(32'hBC00_3C00, 2'b00, 2'b00, 0, 1, 0, 0, 0, 16'h3C00, 16'h3C00, "R10 abs");
        send(32'hBC00_3C00, 2'b00, 2'b00, 1, 0, 0, 0, 0, 16'hBC00, 16'h3C00, "R10 neg");
        send(32'hBC00_3C00, 2'b00, 2'b00, 1, 1, 0, 0, 0, 16'hBC00, 16'hBC00, "R10 abs then neg");
        send(32'h0001_0001, 2'b00, 2'b00, 1, 1, 1, 0, 0, 16'h8000, 16'h8000, "R10 R9 flush abs neg");
        // immediates
        send(32'hFFFF_FFFF, 2'b10, 2'b10, 1, 1, 0, 10'h0F0, 10'h100, 16'h4000, 16'h3C00, "R11 immediate");
        send(32'h1234_5678, 2'b10, 2'b01, 0, 0, 1, 10'h201, 10'h001, 16'h0000, 16'h8000, "R11 R9 immediate flush");
        // constants
        send(32'hBF80_0000, 2'b01, 2'b00, 0, 1, 0, 0, 0, 16'hBC00, 16'hBC00, "R12 constant abs ignored");
        send(32'hBF80_0000, 2'b01, 2'b10, 1, 0, 0, 0, 0, 16'h3C00, 16'h3C00, "R12 constant neg");

        @(negedge clk);
        in_valid = 1'b0;
        src_word = 32'hDEAD_BEEF; swz_mode = 2'b10;
        @(posedge clk);
        #1;
        h0 = lane0; h1 = lane1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || lane0 !== h0 || lane1 !== h1) begin
            failures++;
            $display("FAIL R2 idle hold actual=%b %h/%h expected=0 %h/%h", out_valid, lane0, lane1, h0, h1);
        end
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing outputs actual=%0d expected=0", sb_q.size());
        end
        finished = 1'b1;
        report();
    end
endmodule